// File: doc/BRIEF.md
# Tag-Forwarding Reservation Station

This block is the issue buffer in front of a single fixed-point execution unit in an out-of-order core. Operands are fetched when an operation is dispatched, so every buffered operation carries its own operand storage. Each of the two operand fields holds one of two things. When the operand's ready flag is set, the field holds the operand value. When the flag is clear, the low bits of the field hold the tag of the result buffer that will produce the value.

The block watches the result bus. When a result appears, every waiting operand field whose tag matches takes the value and sets its ready flag. A result that appears in the same cycle as a dispatch is also forwarded into the new operation. Each cycle the block sends at most one operation whose operands are both ready to the execution unit, and it picks the one that was dispatched first. When every slot is occupied, the block holds off dispatch. A flush input empties the buffer.

Top module: `tagfwd_rs`

## Requirements
- R1: After a synchronous reset no operation is issued and `disp_ready` is high.
- R2: At dispatch, an operand whose ready flag is set is stored as a value. Such a stored value is never replaced by a later result, even when its low bits equal the result tag.
- R3: A result with `res_valid` high and tag T fills, in every occupied slot, each operand that is not ready and whose low `TAG_W` bits equal T. The slot can then be issued from the next cycle on.
- R4: A result on the bus in the same cycle as a dispatch is captured into each operand of the new operation that is waiting on the matching tag.
- R5: `iss_valid` is high only for an operation whose two operands are both ready. At most one operation issues per cycle. The issued operation's opcode, destination tag and two operand values appear on the `iss_*` ports.
- R6: When several buffered operations are ready, the one dispatched earliest is issued first.
- R7: When all slots are occupied, `disp_ready` is low and a dispatch attempt is ignored. The ignored operation never issues.
- R8: The slot of an issued operation accepts a new dispatch in the very next cycle.
- R9: While `flush` is high, nothing issues and `disp_ready` is low. After the flush every slot is empty, and a dispatch offered in the flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard every buffered operation |
| disp_valid | input | 1 | A dispatch is offered |
| disp_ready | output | 1 | A free slot exists and no flush is in progress |
| disp_op | input | OP_W (6) | Operation code |
| disp_dst | input | TAG_W (5) | Destination result buffer tag |
| disp_a_rdy | input | 1 | Operand A is a value (1) or a tag (0) |
| disp_a | input | DATA_W (32) | Operand A value, or its tag in the low TAG_W bits |
| disp_b_rdy | input | 1 | Operand B is a value (1) or a tag (0) |
| disp_b | input | DATA_W (32) | Operand B value, or its tag in the low TAG_W bits |
| res_valid | input | 1 | A result is on the bus |
| res_tag | input | TAG_W (5) | Tag of the result |
| res_data | input | DATA_W (32) | Result value |
| iss_valid | output | 1 | An operation is issued this cycle |
| iss_op | output | OP_W (6) | Issued operation code |
| iss_dst | output | TAG_W (5) | Issued destination tag |
| iss_a | output | DATA_W (32) | Issued operand A value |
| iss_b | output | DATA_W (32) | Issued operand B value |

## Verification
The bench builds the station with `ENTRIES` set to 4 and the package widths left at their defaults. Four slots let a short sequence fill the buffer, so the stall condition and the reuse of a freed slot in the next cycle are easy to reach. A table of cycles covers several patterns. Younger operations wake up before older ones, two waiting operations are released by one result, a value whose low bits match a result tag must stay unchanged, and a flush arrives together with a dispatch.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int DATA_W = 32;
    localparam int TAG_W  = 5;
    localparam int OP_W   = 6;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [OP_W-1:0]   op_t;

    // Operand field: value when rdy is set, else tag in the low bits.
    typedef struct packed {
        logic  rdy;
        word_t fld;
    } opnd_t;

    typedef struct packed {
        logic  busy;
        op_t   op;
        tag_t  dst;
        opnd_t a;
        opnd_t b;
    } rs_entry_t;

    // Forward a broadcast result into an operand that waits on its tag.
    function automatic opnd_t snoop(opnd_t o, logic hit_v, tag_t hit_tag, word_t hit_data);
        opnd_t r;
        r = o;
        if (!o.rdy && hit_v && (o.fld[TAG_W-1:0] == hit_tag)) begin
            r.rdy = 1'b1;
            r.fld = hit_data;
        end
        return r;
    endfunction

    function automatic logic can_issue(rs_entry_t e);
        return e.busy && e.a.rdy && e.b.rdy;
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      alloc,
    input  op_t       in_op,
    input  tag_t      in_dst,
    input  opnd_t     in_a,
    input  opnd_t     in_b,
    input  logic      res_v,
    input  tag_t      res_tag,
    input  word_t     res_data,
    input  logic      clr,
    output rs_entry_t ent,
    output logic      rdy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (flush) begin
            ent.busy <= 1'b0;
        end else if (alloc) begin
            ent.busy <= 1'b1;
            ent.op   <= in_op;
            ent.dst  <= in_dst;
            ent.a    <= snoop(in_a, res_v, res_tag, res_data);
            ent.b    <= snoop(in_b, res_v, res_tag, res_data);
        end else if (clr) begin
            ent.busy <= 1'b0;
        end else if (ent.busy) begin
            ent.a <= snoop(ent.a, res_v, res_tag, res_data);
            ent.b <= snoop(ent.b, res_v, res_tag, res_data);
        end
    end

    assign rdy = can_issue(ent);

    // R3: a waiting operand captures the matching result
    assert_capture_a_R3: assert property (@(posedge clk) disable iff (rst)
        (ent.busy && !ent.a.rdy && res_v && ent.a.fld[TAG_W-1:0] == res_tag && !clr && !flush && !alloc)
        |=> (ent.a.rdy && ent.a.fld == $past(res_data)));

    assert_capture_b_R3: assert property (@(posedge clk) disable iff (rst)
        (ent.busy && !ent.b.rdy && res_v && ent.b.fld[TAG_W-1:0] == res_tag && !clr && !flush && !alloc)
        |=> (ent.b.rdy && ent.b.fld == $past(res_data)));

    // R2: a ready operand is never overwritten while the slot lives
    assert_value_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (ent.busy && ent.a.rdy && ent.b.rdy && !clr && !flush && !alloc)
        |=> ($stable(ent.a) && $stable(ent.b)));

    // R4: same-cycle result is bypassed into the new operation
    assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
        (alloc && !flush && !in_a.rdy && res_v && in_a.fld[TAG_W-1:0] == res_tag)
        |=> (ent.a.rdy && ent.a.fld == $past(res_data)));

endmodule

// File: rtl/rs_lowpick.sv
module rs_lowpick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_age.sv
module rs_age #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] alloc_oh,
    input  logic [N-1:0] busy,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // older[i][j] set: slot i was dispatched before slot j
    logic [N-1:0][N-1:0] older;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                always_ff @(posedge clk) older[i][j] <= 1'b0;
            end else begin : g_off
                always_ff @(posedge clk) begin
                    if (rst)              older[i][j] <= 1'b0;
                    else if (alloc_oh[i]) older[i][j] <= 1'b0;
                    else if (alloc_oh[j]) older[i][j] <= 1'b1;
                end
                if (i < j) begin : g_chk
                    // R6: two live slots always have a strict order
                    assert_age_order_R6: assert property (@(posedge clk) disable iff (rst)
                        (busy[i] && busy[j]) |-> (older[i][j] != older[j][i]));
                end
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_gnt
        logic [N-1:0] elder;
        for (genvar j = 0; j < N; j++) begin : g_e
            assign elder[j] = older[j][i];
        end
        assign grant[i] = req[i] && !(|(req & elder));
    end

    // R5: at most one slot is granted
    assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/tagfwd_rs.sv
module tagfwd_rs
    import rs_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic              disp_a_rdy,
    input  logic [DATA_W-1:0] disp_a,
    input  logic              disp_b_rdy,
    input  logic [DATA_W-1:0] disp_b,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b
);

    rs_entry_t          ents [ENTRIES];
    logic [ENTRIES-1:0] busy;
    logic [ENTRIES-1:0] ready;
    logic [ENTRIES-1:0] free_pick;
    logic [ENTRIES-1:0] alloc_oh;
    logic [ENTRIES-1:0] grant;
    logic [ENTRIES-1:0] clr;
    logic               take;
    opnd_t              in_a;
    opnd_t              in_b;
    rs_entry_t          sel;

    assign in_a = '{rdy: disp_a_rdy, fld: disp_a};
    assign in_b = '{rdy: disp_b_rdy, fld: disp_b};

    assign disp_ready = (|(~busy)) && !flush;
    assign take       = disp_valid && disp_ready;
    assign alloc_oh   = free_pick & {ENTRIES{take}};
    assign clr        = grant & {ENTRIES{!flush}};

    rs_lowpick #(.N(ENTRIES)) u_free (
        .req  (~busy),
        .pick (free_pick)
    );

    rs_age #(.N(ENTRIES)) u_age (
        .clk      (clk),
        .rst      (rst),
        .alloc_oh (alloc_oh),
        .busy     (busy),
        .req      (ready),
        .grant    (grant)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        rs_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .alloc    (alloc_oh[i]),
            .in_op    (disp_op),
            .in_dst   (disp_dst),
            .in_a     (in_a),
            .in_b     (in_b),
            .res_v    (res_valid),
            .res_tag  (res_tag),
            .res_data (res_data),
            .clr      (clr[i]),
            .ent      (ents[i]),
            .rdy      (ready[i])
        );
        assign busy[i] = ents[i].busy;
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (grant[i]) sel = rs_entry_t'(sel | ents[i]);
        end
    end

    assign iss_valid = (|ready) && !flush;
    assign iss_op    = sel.op;
    assign iss_dst   = sel.dst;
    assign iss_a     = sel.a.fld;
    assign iss_b     = sel.b.fld;

    // R1: reset leaves every slot empty
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (busy == '0));

    // R5: an issued operation has both operands ready
    assert_issue_ready_R5: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (|(grant & ready)));

    // R7: no dispatch accepted while full
    assert_full_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (&busy) |-> !disp_ready);

    // R8: allocation only targets a free slot
    assert_alloc_free_R8: assert property (@(posedge clk) disable iff (rst)
        (|alloc_oh) |-> ($onehot0(alloc_oh) && ((alloc_oh & busy) == '0)));

    // R9: flush empties the buffer
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (busy == '0));

endmodule

// File: tb/tagfwd_rs_bench.sv
`timescale 1ns/1ps
module tagfwd_rs_bench;
    import rs_pkg::*;

    localparam int ENTRIES = 4;
    localparam int NROWS   = 39;

    typedef struct packed {
        logic [3:0]  rq;
        logic        fl;
        logic        dv;
        logic [4:0]  dst;
        logic        av;
        logic [31:0] a;
        logic        bv;
        logic [31:0] b;
        logic        rv;
        logic [4:0]  rtag;
        logic [31:0] rdata;
        logic        eiv;
        logic [4:0]  edst;
        logic [31:0] ea;
        logic [31:0] eb;
        logic        erdy;
    } vec_t;

    function automatic vec_t mk(int rq, bit fl, bit dv, int dst, bit av, int a, bit bv, int b,
                                bit rv, int rtag, int rdata, bit eiv, int edst, int ea, int eb, bit erdy);
        vec_t v;
        v.rq = rq[3:0]; v.fl = fl; v.dv = dv; v.dst = dst[4:0];
        v.av = av; v.a = a; v.bv = bv; v.b = b;
        v.rv = rv; v.rtag = rtag[4:0]; v.rdata = rdata;
        v.eiv = eiv; v.edst = edst[4:0]; v.ea = ea; v.eb = eb; v.erdy = erdy;
        return v;
    endfunction

    // rq  fl dv dst av a   bv b   rv tag data   eiv edst ea   eb   erdy
    localparam vec_t TBL [NROWS] = '{
        mk(1, 0,0, 0, 0,0,  0,0,  0,0,0,       0,0, 0,0, 1),      // R1 empty after reset
        mk(2, 0,1, 1, 1,10, 1,20, 0,0,0,       0,0, 0,0, 1),      // R2 both values
        mk(5, 0,0, 0, 0,0,  0,0,  0,0,0,       1,1, 10,20, 1),    // R5 issue next cycle
        mk(2, 0,1, 2, 1,7,  0,7,  0,0,0,       0,0, 0,0, 1),      // R2 value 7, tag 7
        mk(2, 0,1, 3, 0,7,  0,8,  0,0,0,       0,0, 0,0, 1),
        mk(4, 0,1, 4, 0,7,  1,3,  1,7,77,      0,0, 0,0, 1),      // R4 bypass tag 7
        mk(2, 0,0, 0, 0,0,  0,0,  0,0,0,       1,2, 7,77, 1),     // R2 value 7 kept, R3 b=77
        mk(4, 0,0, 0, 0,0,  0,0,  0,0,0,       1,4, 77,3, 1),     // R4 bypassed value
        mk(3, 0,0, 0, 0,0,  0,0,  1,8,88,      0,0, 0,0, 1),      // R3 no issue yet
        mk(3, 0,0, 0, 0,0,  0,0,  0,0,0,       1,3, 77,88, 1),    // R3 both captured
        mk(5, 0,0, 0, 0,0,  0,0,  0,0,0,       0,0, 0,0, 1),
        mk(6, 0,1, 5, 0,9,  1,1,  0,0,0,       0,0, 0,0, 1),
        mk(6, 0,1, 6, 1,2,  1,3,  0,0,0,       0,0, 0,0, 1),
        mk(6, 0,0, 0, 0,0,  0,0,  1,9,99,      1,6, 2,3, 1),      // R6 younger ready goes
        mk(3, 0,0, 0, 0,0,  0,0,  0,0,0,       1,5, 99,1, 1),
        mk(6, 0,1, 10,0,11, 0,11, 0,0,0,       0,0, 0,0, 1),
        mk(6, 0,1, 12,0,11, 1,4,  0,0,0,       0,0, 0,0, 1),
        mk(3, 0,0, 0, 0,0,  0,0,  1,11,171,    0,0, 0,0, 1),
        mk(6, 0,0, 0, 0,0,  0,0,  0,0,0,       1,10, 171,171, 1), // R6 oldest first
        mk(6, 0,0, 0, 0,0,  0,0,  0,0,0,       1,12, 171,4, 1),
        mk(7, 0,1, 13,0,20, 1,0,  0,0,0,       0,0, 0,0, 1),
        mk(7, 0,1, 14,0,20, 1,0,  0,0,0,       0,0, 0,0, 1),
        mk(7, 0,1, 15,0,20, 1,0,  0,0,0,       0,0, 0,0, 1),
        mk(7, 0,1, 16,0,20, 1,0,  0,0,0,       0,0, 0,0, 1),
        mk(7, 0,1, 31,1,1,  1,1,  0,0,0,       0,0, 0,0, 0),      // R7 full, dropped
        mk(7, 0,0, 0, 0,0,  0,0,  1,20,85,     0,0, 0,0, 0),
        mk(6, 0,0, 0, 0,0,  0,0,  0,0,0,       1,13, 85,0, 0),
        mk(8, 0,1, 17,1,7,  1,8,  0,0,0,       1,14, 85,0, 1),    // R8 reuse freed slot
        mk(6, 0,0, 0, 0,0,  0,0,  0,0,0,       1,15, 85,0, 1),
        mk(6, 0,0, 0, 0,0,  0,0,  0,0,0,       1,16, 85,0, 1),
        mk(7, 0,0, 0, 0,0,  0,0,  0,0,0,       1,17, 7,8, 1),     // R7 tag 31 absent
        mk(7, 0,0, 0, 0,0,  0,0,  0,0,0,       0,0, 0,0, 1),
        mk(9, 0,1, 18,0,3,  1,0,  0,0,0,       0,0, 0,0, 1),
        mk(9, 0,1, 19,1,1,  1,1,  0,0,0,       0,0, 0,0, 1),
        mk(9, 1,0, 0, 0,0,  0,0,  0,0,0,       0,0, 0,0, 0),      // R9 flush blocks issue
        mk(9, 0,0, 0, 0,0,  0,0,  1,3,51,      0,0, 0,0, 1),      // R9 emptied
        mk(9, 0,0, 0, 0,0,  0,0,  0,0,0,       0,0, 0,0, 1),
        mk(9, 1,1, 21,1,1,  1,1,  0,0,0,       0,0, 0,0, 0),      // R9 dispatch dropped
        mk(9, 0,0, 0, 0,0,  0,0,  0,0,0,       0,0, 0,0, 1)
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic              disp_valid = 1'b0;
    logic              disp_ready;
    logic [OP_W-1:0]   disp_op = '0;
    logic [TAG_W-1:0]  disp_dst = '0;
    logic              disp_a_rdy = 1'b0;
    logic [DATA_W-1:0] disp_a = '0;
    logic              disp_b_rdy = 1'b0;
    logic [DATA_W-1:0] disp_b = '0;
    logic              res_valid = 1'b0;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [DATA_W-1:0] res_data = '0;
    logic              iss_valid;
    logic [OP_W-1:0]   iss_op;
    logic [TAG_W-1:0]  iss_dst;
    logic [DATA_W-1:0] iss_a;
    logic [DATA_W-1:0] iss_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tagfwd_rs #(.ENTRIES(ENTRIES)) u_tagfwd_rs (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_a_rdy(disp_a_rdy), .disp_a(disp_a),
        .disp_b_rdy(disp_b_rdy), .disp_b(disp_b),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic check(int rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        flush      = v.fl;
        disp_valid = v.dv;
        disp_dst   = v.dst;
        disp_op    = {1'b1, v.dst};
        disp_a_rdy = v.av;
        disp_a     = v.a;
        disp_b_rdy = v.bv;
        disp_b     = v.b;
        res_valid  = v.rv;
        res_tag    = v.rtag;
        res_data   = v.rdata;
    endtask

    task automatic expect_row(int idx, vec_t v);
        check(v.rq, $sformatf("row %0d disp_ready", idx), 64'(disp_ready), 64'(v.erdy));
        check(v.rq, $sformatf("row %0d iss_valid", idx), 64'(iss_valid), 64'(v.eiv));
        if (v.eiv && iss_valid) begin
            check(v.rq, $sformatf("row %0d iss_dst", idx), 64'(iss_dst), 64'(v.edst));
            check(v.rq, $sformatf("row %0d iss_op", idx), 64'(iss_op), 64'({1'b1, v.edst}));
            check(v.rq, $sformatf("row %0d iss_a", idx), 64'(iss_a), 64'(v.ea));
            check(v.rq, $sformatf("row %0d iss_b", idx), 64'(iss_b), 64'(v.eb));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NROWS; i++) begin
            drive(TBL[i]);
            #1;
            expect_row(i, TBL[i]);
            @(negedge clk);
        end
        drive('0);

        // R1: reset in the middle of traffic discards a ready operation
        disp_valid = 1'b1; disp_dst = 5'd22; disp_op = 6'd1;
        disp_a_rdy = 1'b1; disp_a = 32'd5; disp_b_rdy = 1'b1; disp_b = 32'd6;
        @(negedge clk);
        disp_valid = 1'b0;
        #1;
        check(1, "ready op present before reset", 64'(iss_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(1, "iss_valid after reset", 64'(iss_valid), 64'd0);
        check(1, "disp_ready after reset", 64'(disp_ready), 64'd1);

        // R4: both operands wait on the same tag that arrives with the dispatch
        @(negedge clk);
        disp_valid = 1'b1; disp_dst = 5'd23; disp_op = 6'd2;
        disp_a_rdy = 1'b0; disp_a = 32'd6; disp_b_rdy = 1'b0; disp_b = 32'd6;
        res_valid = 1'b1; res_tag = 5'd6; res_data = 32'hDEAD_BEEF;
        @(negedge clk);
        drive('0);
        #1;
        check(4, "double bypass issue", 64'(iss_valid), 64'd1);
        check(4, "double bypass a", 64'(iss_a), 64'hDEAD_BEEF);
        check(4, "double bypass b", 64'(iss_b), 64'hDEAD_BEEF);
        @(negedge clk);
        #1;
        check(5, "drained", 64'(iss_valid), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule